// File: doc/BRIEF.md
# VME Interrupter with Acknowledge Daisy Chain

This block lets a VME card raise an interrupt on one of the seven active-low request lines and answer the acknowledge cycle that follows. A local request pulse marks the interrupt as pending. While it is pending and the configured level is between 1 and 7, the line for that level is held low. Level 0 switches interrupts off.

During an acknowledge cycle the handler drives IACK and IACKIN low and puts the acknowledged level on A[3:1] (address modifier 0x29). It then drives AS low, followed by DS0. The block compares that level with its own. If they match and a request is pending, it answers:

- the 8-bit status/ID vector goes onto the data lines;
- DTACK is asserted;
- the request line is released on the same clock edge.

In every other case it passes the acknowledge down the daisy chain by asserting IACKOUT.

All bus inputs pass through a synchronizer of parameterized depth before any decision is made. Outputs are registered, and tristate control is left to the pad ring: the block supplies `data_oe_o` for that purpose.

Top module: `irq_interrupter`

## Requirements
- R1: After reset, `irq_n_o` is 7'h7F, `iackout_n_o` and `dtack_n_o` are 1 and `data_oe_o` is 0.
- R2: A one-cycle `req_i` pulse with `level_i` = L (1..7) drives bit L-1 of `irq_n_o` low. No other bit goes low, and the bit stays low until the request is served.
- R3: With `level_i` = 0 no request line is ever driven, a pending request is dropped, and every acknowledge cycle is forwarded on `iackout_n_o`.
- R4: When `iack_n_i`, `iackin_n_i`, `as_n_i` and `ds0_n_i` are all low, `ack_lvl_i` equals `level_i` and a request is pending, the block answers within 4 clock cycles: `dtack_n_o` = 0, `data_oe_o` = 1, `data_o` = the vector, and `iackout_n_o` stays 1.
- R5: The request line is released on the same clock edge on which `dtack_n_o` falls, and the pending request is cleared.
- R6: Within 4 cycles of `ds0_n_i` rising, `dtack_n_o` returns to 1 and `data_oe_o` to 0, even while `iackin_n_i` is still low.
- R7: An acknowledge cycle whose level differs, or that arrives with nothing pending, drives `iackout_n_o` low within 4 cycles and leaves `dtack_n_o` at 1.
- R8: `iackout_n_o` stays low while `iackin_n_i` is low, even after DS0 rises, and returns to 1 within 4 cycles of `iackin_n_i` rising.
- R9: The block neither answers nor forwards unless both `as_n_i` and `iack_n_i` are low.
- R10: The vector is captured when the answer starts; later changes of `vector_i` do not alter `data_o` during that answer.
- R11: If `level_i` changes while a request is pending, the driven line moves to the new level, and the acknowledge is matched against the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Local interrupt request pulse, synchronous to clk |
| level_i | input | 3 | Configured interrupt level, 0 = disabled |
| vector_i | input | 8 | Status/ID vector returned on acknowledge |
| iack_n_i | input | 1 | Bus IACK, active low |
| iackin_n_i | input | 1 | Daisy-chain acknowledge in, active low |
| as_n_i | input | 1 | Address strobe, active low |
| ds0_n_i | input | 1 | Data strobe 0, active low |
| ack_lvl_i | input | 3 | Acknowledged level taken from A[3:1] |
| irq_n_o | output | 7 | Request lines, bit k = level k+1, active low |
| iackout_n_o | output | 1 | Daisy-chain acknowledge out, active low |
| dtack_n_o | output | 1 | Data acknowledge, active low |
| data_o | output | 8 | Vector for D[7:0] |
| data_oe_o | output | 1 | Enable for the D[7:0] drivers |

## Verification
The bench builds the block with its defaults: two synchronizer stages, seven levels and an 8-bit vector. With the two-stage chain, every strobe takes three clock edges to reach an output, so the bench samples five cycles after each bus event. That window is long enough to observe every hand-off of the acknowledge cycle separately. The seven-level default covers both end levels 1 and 7 as well as the disabled level 0, and it lets a request that is still pending be carried into a later cycle at a different level.

// File: rtl/vi_pkg.sv
package vi_pkg;
    localparam int LVL_W = 3;
    localparam int N_LVL = 7;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESP  = 2'd1,
        ST_FWD   = 2'd2,
        ST_DRAIN = 2'd3
    } ack_st_e;

    typedef struct packed {
        ack_st_e            st;
        logic               dtack_n;
        logic               iackout_n;
        logic               oe;
        logic [VEC_W-1:0]   vec;
    } ack_regs_t;
endpackage

// File: rtl/vi_sync.sv
module vi_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vi_request.sv
module vi_request
    import vi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             serve_i,
    output logic             pending_o,
    output logic [N_LVL-1:0] irq_n_o
);
    typedef struct packed {
        logic             pend;
        logic [N_LVL-1:0] irq_n;
    } rq_regs_t;

    rq_regs_t         rq_d, rq_q;
    logic [N_LVL-1:0] lvl_sel;
    logic             lvl_on;

    // one-hot decode of the configured level
    for (genvar g = 0; g < N_LVL; g++) begin : g_dec
        assign lvl_sel[g] = (level_i == LVL_W'(g + 1));
    end

    assign lvl_on = |lvl_sel;

    always_comb begin
        rq_d = rq_q;
        if (serve_i)          rq_d.pend = 1'b0;
        if (req_i && lvl_on)  rq_d.pend = 1'b1;
        if (!lvl_on)          rq_d.pend = 1'b0;
        rq_d.irq_n = ~(lvl_sel & {N_LVL{rq_d.pend}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q.pend  <= 1'b0;
            rq_q.irq_n <= '1;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign pending_o = rq_q.pend;
    assign irq_n_o   = rq_q.irq_n;

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n_o) <= 1); // R2

    AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_i) == '0) |-> (irq_n_o == '1)); // R3
endmodule

// File: rtl/vi_ack_fsm.sv
module vi_ack_fsm
    import vi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_n_i,
    input  logic             iackin_n_i,
    input  logic             as_n_i,
    input  logic             ds_n_i,
    input  logic [LVL_W-1:0] ack_lvl_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             pending_i,
    input  logic [VEC_W-1:0] vector_i,
    output logic             serve_o,
    output logic             dtack_n_o,
    output logic             iackout_n_o,
    output logic             data_oe_o,
    output logic [VEC_W-1:0] data_o
);
    ack_regs_t fsm_d, fsm_q;
    logic      ack_cyc;
    logic      ours;

    assign ack_cyc = !iack_n_i && !iackin_n_i && !as_n_i && !ds_n_i;
    assign ours    = pending_i && (level_i != '0) && (ack_lvl_i == level_i);

    always_comb begin
        fsm_d   = fsm_q;
        serve_o = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (ack_cyc) begin
                    if (ours) begin
                        fsm_d.st      = ST_RESP;
                        fsm_d.dtack_n = 1'b0;
                        fsm_d.oe      = 1'b1;
                        fsm_d.vec     = vector_i;
                        serve_o       = 1'b1;
                    end else begin
                        fsm_d.st        = ST_FWD;
                        fsm_d.iackout_n = 1'b0;
                    end
                end
            end
            ST_RESP: begin
                if (ds_n_i || iackin_n_i) begin
                    fsm_d.dtack_n = 1'b1;
                    fsm_d.oe      = 1'b0;
                    fsm_d.st      = iackin_n_i ? ST_IDLE : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (iackin_n_i) fsm_d.st = ST_IDLE;
            end
            ST_FWD: begin
                if (iackin_n_i) begin
                    fsm_d.iackout_n = 1'b1;
                    fsm_d.st        = ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st        <= ST_IDLE;
            fsm_q.dtack_n   <= 1'b1;
            fsm_q.iackout_n <= 1'b1;
            fsm_q.oe        <= 1'b0;
            fsm_q.vec       <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign dtack_n_o   = fsm_q.dtack_n;
    assign iackout_n_o = fsm_q.iackout_n;
    assign data_oe_o   = fsm_q.oe;
    assign data_o      = fsm_q.oe ? fsm_q.vec : '0;

    AST_DTACK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n_o |-> data_oe_o); // R4

    AST_ANSWER_OR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n_o && !iackout_n_o)); // R7

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o)) |-> $stable(data_o)); // R10
endmodule

// File: rtl/irq_interrupter.sv
module irq_interrupter
    import vi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [2:0]       level_i,
    input  logic [7:0]       vector_i,
    input  logic             iack_n_i,
    input  logic             iackin_n_i,
    input  logic             as_n_i,
    input  logic             ds0_n_i,
    input  logic [2:0]       ack_lvl_i,
    output logic [6:0]       irq_n_o,
    output logic             iackout_n_o,
    output logic             dtack_n_o,
    output logic [7:0]       data_o,
    output logic             data_oe_o
);
    localparam int CTL_W = 4;

    logic [CTL_W-1:0] ctl_s;
    logic [LVL_W-1:0] lvl_s;
    logic             serve_w;
    logic             pending_w;

    vi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ctl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({iack_n_i, iackin_n_i, as_n_i, ds0_n_i}),
        .q_o  (ctl_s)
    );

    vi_sync #(.W(LVL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_lvl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ack_lvl_i),
        .q_o  (lvl_s)
    );

    vi_request u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .level_i  (level_i),
        .serve_i  (serve_w),
        .pending_o(pending_w),
        .irq_n_o  (irq_n_o)
    );

    vi_ack_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .iack_n_i   (ctl_s[3]),
        .iackin_n_i (ctl_s[2]),
        .as_n_i     (ctl_s[1]),
        .ds_n_i     (ctl_s[0]),
        .ack_lvl_i  (lvl_s),
        .level_i    (level_i),
        .pending_i  (pending_w),
        .vector_i   (vector_i),
        .serve_o    (serve_w),
        .dtack_n_o  (dtack_n_o),
        .iackout_n_o(iackout_n_o),
        .data_oe_o  (data_oe_o),
        .data_o     (data_o)
    );

    AST_PASS_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !iackout_n_o |-> !$past(ctl_s[2])); // R8

    AST_SERVE_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n_o) |-> (irq_n_o == '1 || $past(req_i))); // R5
endmodule

// File: tb/irq_interrupter_bench.sv
module irq_interrupter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic [2:0] level_i = '0;
    logic [7:0] vector_i = '0;
    logic       iack_n_i = 1'b1;
    logic       iackin_n_i = 1'b1;
    logic       as_n_i = 1'b1;
    logic       ds0_n_i = 1'b1;
    logic [2:0] ack_lvl_i = '0;
    logic [6:0] irq_n_o;
    logic       iackout_n_o;
    logic       dtack_n_o;
    logic [7:0] data_o;
    logic       data_oe_o;

    int errors = 0;
    int checks = 0;
    bit pend_m = 1'b0;

    always #5 clk = ~clk;

    irq_interrupter u_irq_interrupter (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_i(level_i),
        .vector_i(vector_i), .iack_n_i(iack_n_i), .iackin_n_i(iackin_n_i),
        .as_n_i(as_n_i), .ds0_n_i(ds0_n_i), .ack_lvl_i(ack_lvl_i),
        .irq_n_o(irq_n_o), .iackout_n_o(iackout_n_o), .dtack_n_o(dtack_n_o),
        .data_o(data_o), .data_oe_o(data_oe_o)
    );

    // {level, req, ack level, vector}
    localparam logic [14:0] TAB [0:8] = '{
        {3'd3, 1'b1, 3'd3, 8'hA5},
        {3'd3, 1'b1, 3'd5, 8'h11},
        {3'd3, 1'b0, 3'd3, 8'h3C},
        {3'd0, 1'b1, 3'd2, 8'h77},
        {3'd7, 1'b1, 3'd7, 8'hFF},
        {3'd1, 1'b1, 3'd1, 8'h00},
        {3'd5, 1'b0, 3'd5, 8'h42},
        {3'd2, 1'b1, 3'd6, 8'h9A},
        {3'd4, 1'b0, 3'd4, 8'hC3}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [6:0] irq_exp(input bit p, input int lv);
        if (p && lv != 0) return ~(7'(1) << (lv - 1));
        return 7'h7F;
    endfunction

    task automatic pulse_req();
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic ack_open(input logic [2:0] al);
        ack_lvl_i = al; iack_n_i = 1'b0; iackin_n_i = 1'b0;
        wait_n(2);
        as_n_i = 1'b0;
        wait_n(2);
        ds0_n_i = 1'b0;
        wait_n(5);
    endtask

    task automatic ack_close();
        ds0_n_i = 1'b1;
        wait_n(2);
        iackin_n_i = 1'b1; iack_n_i = 1'b1; as_n_i = 1'b1;
        wait_n(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_n(3);
        // R1 reset state
        chk("R1 irq", 32'(irq_n_o), 32'h7F);
        chk("R1 iackout", 32'(iackout_n_o), 32'h1);
        chk("R1 dtack", 32'(dtack_n_o), 32'h1);
        chk("R1 oe", 32'(data_oe_o), 32'h0);
        rst_n = 1'b1;
        wait_n(3);

        for (int r = 0; r < 9; r++) begin
            int lv, al;
            bit rq, resp;
            logic [7:0] vec;
            lv = int'(TAB[r][14:12]); rq = TAB[r][11];
            al = int'(TAB[r][10:8]); vec = TAB[r][7:0];
            level_i = 3'(lv); vector_i = vec;
            if (rq) pulse_req();
            if (rq && lv != 0) pend_m = 1'b1;
            if (lv == 0) pend_m = 1'b0;
            wait_n(3);
            chk("R2/R3/R11 irq line", 32'(irq_n_o), 32'(irq_exp(pend_m, lv)));
            resp = pend_m && lv != 0 && al == lv;
            ack_open(3'(al));
            if (resp) begin
                pend_m = 1'b0;
                chk("R4 dtack", 32'(dtack_n_o), 32'h0);
                chk("R4 vector", 32'(data_o), 32'(vec));
                chk("R4 no pass", 32'(iackout_n_o), 32'h1);
                chk("R5 line freed", 32'(irq_n_o), 32'h7F);
            end else begin
                chk("R7 pass", 32'(iackout_n_o), 32'h0);
                chk("R7 no dtack", 32'(dtack_n_o), 32'h1);
                chk("R7 no oe", 32'(data_oe_o), 32'h0);
            end
            ds0_n_i = 1'b1;
            wait_n(5);
            chk("R6 dtack off", 32'(dtack_n_o), 32'h1);
            chk("R6 oe off", 32'(data_oe_o), 32'h0);
            if (!resp) chk("R8 pass held", 32'(iackout_n_o), 32'h0);
            iackin_n_i = 1'b1; iack_n_i = 1'b1; as_n_i = 1'b1;
            wait_n(5);
            chk("R8 pass released", 32'(iackout_n_o), 32'h1);
            chk("R2 line after cycle", 32'(irq_n_o), 32'(irq_exp(pend_m, lv)));
        end

        // R9: AS high blocks both answer and pass
        level_i = 3'd3; pulse_req(); wait_n(3);
        ack_lvl_i = 3'd3; iack_n_i = 1'b0; iackin_n_i = 1'b0; ds0_n_i = 1'b0;
        wait_n(6);
        chk("R9 as high no pass", 32'(iackout_n_o), 32'h1);
        chk("R9 as high no dtack", 32'(dtack_n_o), 32'h1);
        iack_n_i = 1'b1; iackin_n_i = 1'b1; ds0_n_i = 1'b1; wait_n(5);
        // R9: IACK high blocks both
        iackin_n_i = 1'b0; as_n_i = 1'b0; ds0_n_i = 1'b0;
        wait_n(6);
        chk("R9 iack high no pass", 32'(iackout_n_o), 32'h1);
        chk("R9 iack high no dtack", 32'(dtack_n_o), 32'h1);
        chk("R9 still pending", 32'(irq_n_o), 32'h7B);
        iackin_n_i = 1'b1; as_n_i = 1'b1; ds0_n_i = 1'b1; wait_n(5);

        // R10: vector captured at answer start
        vector_i = 8'hA1;
        ack_open(3'd3);
        chk("R10 vec", 32'(data_o), 32'hA1);
        vector_i = 8'h5E;
        wait_n(3);
        chk("R10 vec held", 32'(data_o), 32'hA1);
        ack_close();

        // R3: dropping level to 0 discards the pending request
        pulse_req(); wait_n(2);
        chk("R3 line low", 32'(irq_n_o), 32'h7B);
        level_i = 3'd0; wait_n(2);
        chk("R3 off at level 0", 32'(irq_n_o), 32'h7F);
        level_i = 3'd3; wait_n(2);
        chk("R3 request dropped", 32'(irq_n_o), 32'h7F);
        level_i = 3'd0;
        ack_open(3'd0);
        chk("R3 level 0 passes", 32'(iackout_n_o), 32'h0);
        ack_close();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule